// File: doc/BRIEF.md
# Transmit Acknowledgment and Retry Controller

This block takes over once a frame has been handed completely to the physical layer and decides what happens next. Upstream logic asks for a transmission. The block then holds the transmit enable until the end-of-frame strobe arrives, and reads the frame's acknowledgment policy on that same strobe. A frame that needs no acknowledgment is reported as complete at once. A frame that asks for an immediate acknowledgment makes the block drop the transmit enable and raise the receive enable. It then listens for a programmable number of clock cycles.

A valid acknowledgment seen inside that listening window ends the exchange with a success completion. If the window runs out first, the block does one of two things. While the retry budget is not used up, it requests a retransmission and counts it. Upstream is expected to answer with a fresh transmit request. Once the budget is spent, it raises a failure interrupt and resets its retry count. The window length and the retry budget are inputs held stable by the surrounding configuration logic.

Top module: `txack_retry_ctrl`

## Requirements
- R1: After reset, tx_en, rx_en, done_ok, retx_req and fail_irq are 0 and retry_cnt is 0.
- R2: A tx_req sampled while the block is idle makes tx_en 1 from the next cycle until a frame_done is sampled. A tx_req sampled while tx_en or rx_en is 1 has no effect.
- R3: A frame_done sampled while tx_en is 1, with ack_policy not equal to 2'b01 (2'b00 means no acknowledgment, and 2'b10 and 2'b11 are handled the same way), gives tx_en 0, rx_en 0, a one-cycle done_ok pulse and retry_cnt 0 in the next cycle.
- R4: A frame_done sampled while tx_en is 1, with ack_policy equal to 2'b01 (immediate acknowledgment), gives tx_en 0 and rx_en 1 from the next cycle. Without an acknowledgment, rx_en stays 1 for exactly ack_timeout cycles, and a value of 0 counts as 1.
- R5: tx_en and rx_en are never 1 in the same cycle.
- R6: An ack_rx sampled while rx_en is 1 gives rx_en 0, a one-cycle done_ok pulse and retry_cnt 0 in the next cycle. An ack_rx sampled while rx_en is 0 has no effect.
- R7: When the window expires with retry_cnt below retry_limit, the next cycle has rx_en 0, a one-cycle retx_req pulse and retry_cnt increased by one.
- R8: When the window expires with retry_cnt at or above retry_limit, the next cycle has rx_en 0, a one-cycle fail_irq pulse and retry_cnt 0.
- R9: An ack_rx in the last cycle of the window takes priority over expiry: done_ok is pulsed, and neither retx_req nor fail_irq is.
- R10: A frame_done sampled while tx_en is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Start a transmission (pulse, accepted while idle) |
| frame_done | input | 1 | Whole frame delivered to the PHY (pulse) |
| ack_policy | input | 2 | Acknowledgment policy, sampled with frame_done; 2'b01 = immediate acknowledgment |
| ack_rx | input | 1 | Valid acknowledgment frame received (pulse) |
| ack_timeout | input | TW | Listening window length in cycles |
| retry_limit | input | RW | Maximum number of retransmissions |
| tx_en | output | 1 | Transmit enable to the radio |
| rx_en | output | 1 | Receive enable to the radio |
| done_ok | output | 1 | Successful completion pulse |
| retx_req | output | 1 | Retransmission request pulse |
| fail_irq | output | 1 | Failure interrupt pulse after the retry budget is spent |
| retry_cnt | output | RW | Retransmissions made for the current frame |

## Verification
In the final cycle of the listening window, the arrival of an acknowledgment and the expiry of the timer can coincide. The bench provokes this both on purpose and through random acknowledgment timing that includes the last window cycle. The outcome is judged at the ports: the bench expects a done_ok pulse and a cleared retry count, with retx_req and fail_irq both low. Random window lengths of 0 and 1 make this collision happen on the very first listening cycle.

// File: rtl/txack_pkg.sv
// Shared types for the transmit acknowledgment controller.
// Assumes: ack_policy code 2'b01 is the only one that asks for an acknowledgment.
package txack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SEND   = 2'b01,
        ST_LISTEN = 2'b10
    } seq_state_t;

    localparam logic [1:0] POL_IMM_ACK = 2'b01;
endpackage

// File: rtl/txack_ack_timer.sv
// Listening window timer. It is loaded when listening starts and counts down while run is 1.
// last is 1 in the final cycle of the window.
// Assumes: load and run are never 1 together, and a load value of 0 is treated as 1.
module txack_ack_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;

    // Load the window length, or step down toward the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? ONE : load_val;
        end else if (run && cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    // Flag the final window cycle.
    assign last = (cnt == ONE);

    // R4: a running window always holds a nonzero count.
    a_r4_window_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt != '0);
endmodule

// File: rtl/txack_retry_count.sv
// Retry counter. It counts retransmissions of the current frame and reports when the budget is used up.
// Assumes: limit stays stable while a frame is in progress.
module txack_retry_count #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    input  logic [RW-1:0] limit,
    output logic [RW-1:0] count,
    output logic          exhausted
);
    // Clear on completion or failure, and step on each retransmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + RW'(1);
        end
    end

    // The budget is spent once the count reaches the limit.
    assign exhausted = (count >= limit);

    // R7: the sequencer never asks for another retry past the limit.
    a_r7_no_inc_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !exhausted);
    // R8: a single cycle never both clears and steps the count.
    a_r8_inc_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && clr));
endmodule

// File: rtl/txack_retry_ctrl.sv
// Transmit acknowledgment sequencer. It runs send, then listen, then one of complete, retransmit or fail.
// It owns the radio enables and the status pulses.
// Assumes: ack_timeout and retry_limit are stable for the life of a frame.
module txack_retry_ctrl
    import txack_pkg::*;
#(
    parameter int TW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_req,
    input  logic          frame_done,
    input  logic [1:0]    ack_policy,
    input  logic          ack_rx,
    input  logic [TW-1:0] ack_timeout,
    input  logic [RW-1:0] retry_limit,
    output logic          tx_en,
    output logic          rx_en,
    output logic          done_ok,
    output logic          retx_req,
    output logic          fail_irq,
    output logic [RW-1:0] retry_cnt
);
    seq_state_t state, state_nx;
    logic wants_ack, send_end, got_ack, expire;
    logic win_last, budget_spent, rc_inc, rc_clr;

    // Decode the events the sequencer reacts to this cycle.
    always_comb begin
        wants_ack = (ack_policy == POL_IMM_ACK);
        send_end  = (state == ST_SEND) && frame_done;
        got_ack   = (state == ST_LISTEN) && ack_rx;
        expire    = (state == ST_LISTEN) && win_last && !ack_rx;
        rc_inc    = expire && !budget_spent;
        rc_clr    = (send_end && !wants_ack) || got_ack || (expire && budget_spent);
    end

    // Choose the next sequencer state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (tx_req) state_nx = ST_SEND;
            ST_SEND:   if (frame_done) state_nx = wants_ack ? ST_LISTEN : ST_IDLE;
            ST_LISTEN: if (ack_rx || win_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Register the state and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done_ok  <= 1'b0;
            retx_req <= 1'b0;
            fail_irq <= 1'b0;
        end else begin
            state    <= state_nx;
            done_ok  <= (send_end && !wants_ack) || got_ack;
            retx_req <= rc_inc;
            fail_irq <= expire && budget_spent;
        end
    end

    // Drive the radio enables straight from the registered state.
    assign tx_en = (state == ST_SEND);
    assign rx_en = (state == ST_LISTEN);

    txack_ack_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (send_end && wants_ack),
        .load_val (ack_timeout),
        .run      (state == ST_LISTEN),
        .last     (win_last)
    );

    txack_retry_count #(.RW(RW)) i_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (rc_inc),
        .clr       (rc_clr),
        .limit     (retry_limit),
        .count     (retry_cnt),
        .exhausted (budget_spent)
    );

    // R5: the radio is never told to send and listen at once.
    a_r5_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en));
    // R3: a frame that needs no acknowledgment completes in the next cycle.
    a_r3_noack_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && frame_done && ack_policy != 2'b01) |=> (done_ok && !tx_en && !rx_en));
    // R4: an immediate-acknowledgment frame switches the radio to receive.
    a_r4_switch_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && frame_done && ack_policy == 2'b01) |=> (rx_en && !tx_en));
    // R6 and R9: an acknowledgment inside the window wins and completes.
    a_r6_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && ack_rx) |=> (done_ok && !rx_en && !retx_req && !fail_irq));
    // R8: failure leaves the retry count cleared.
    a_r8_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fail_irq |-> retry_cnt == '0);
    // R7: at most one status pulse in any cycle.
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, retx_req, fail_irq}));
    // R10: a stray end-of-frame strobe leaves the block idle.
    a_r10_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en && !tx_req && frame_done) |=> (!tx_en && !rx_en && !done_ok));
endmodule

// File: tb/test_txack_retry_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random frame sequences.
module test_txack_retry_ctrl;
    localparam int TW = 16;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_req = 1'b0;
    logic          frame_done = 1'b0;
    logic [1:0]    ack_policy = 2'b00;
    logic          ack_rx = 1'b0;
    logic [TW-1:0] ack_timeout = '0;
    logic [RW-1:0] retry_limit = '0;
    logic          tx_en, rx_en, done_ok, retx_req, fail_irq;
    logic [RW-1:0] retry_cnt;

    int checks = 0;
    int errors = 0;
    int model_retry = 0;

    always #4 clk = ~clk;

    txack_retry_ctrl #(.TW(TW), .RW(RW)) i_txack_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .frame_done(frame_done),
        .ack_policy(ack_policy), .ack_rx(ack_rx), .ack_timeout(ack_timeout),
        .retry_limit(retry_limit), .tx_en(tx_en), .rx_en(rx_en), .done_ok(done_ok),
        .retx_req(retx_req), .fail_irq(fail_irq), .retry_cnt(retry_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int window_len(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic bit retry_left(input int cnt, input int lim);
        return cnt < lim;
    endfunction

    // One frame: request, send for hold cycles, end with a policy, and an optional ack in window cycle ack_at.
    task automatic run_frame(input logic [1:0] pol, input int hold, input int ack_at);
        int n;
        tx_req = 1'b1; step(); tx_req = 1'b0;
        check("R2 tx_en on request", tx_en, 1);
        for (int h = 0; h < hold; h++) begin
            step();
            check("R2 tx_en held", tx_en, 1);
            check("R5 rx_en low while sending", rx_en, 0);
        end
        frame_done = 1'b1; ack_policy = pol; step(); frame_done = 1'b0;
        if (pol != 2'b01) begin
            check("R3 tx_en dropped", tx_en, 0);
            check("R3 rx_en stays low", rx_en, 0);
            check("R3 done_ok pulse", done_ok, 1);
            check("R3 retry cleared", retry_cnt, 0);
            model_retry = 0;
            step();
            check("R3 done_ok one cycle", done_ok, 0);
            return;
        end
        n = window_len(ack_timeout);
        for (int i = 1; i <= n; i++) begin
            check("R4 rx_en in window", rx_en, 1);
            check("R5 tx_en low in window", tx_en, 0);
            if (ack_at == i) begin
                ack_rx = 1'b1; step(); ack_rx = 1'b0;
                check((i == n) ? "R9 ack wins at last cycle" : "R6 ack done_ok", done_ok, 1);
                check("R6 rx_en dropped", rx_en, 0);
                check("R9 no retx", retx_req, 0);
                check("R9 no fail", fail_irq, 0);
                check("R6 retry cleared", retry_cnt, 0);
                model_retry = 0;
                step();
                return;
            end
            step();
        end
        check("R4 window length", rx_en, 0);
        if (retry_left(model_retry, retry_limit)) begin
            model_retry++;
            check("R7 retx_req pulse", retx_req, 1);
            check("R7 no fail", fail_irq, 0);
            check("R7 retry count", retry_cnt, model_retry);
        end else begin
            model_retry = 0;
            check("R8 fail_irq pulse", fail_irq, 1);
            check("R8 no retx", retx_req, 0);
            check("R8 retry cleared", retry_cnt, 0);
        end
        step();
        check("R7 pulses one cycle", int'(retx_req | fail_irq), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 tx_en", tx_en, 0);
        check("R1 rx_en", rx_en, 0);
        check("R1 done_ok", done_ok, 0);
        check("R1 retx_req", retx_req, 0);
        check("R1 fail_irq", fail_irq, 0);
        check("R1 retry_cnt", retry_cnt, 0);

        // R10 stray frame_done and R6 stray ack while idle
        frame_done = 1'b1; ack_policy = 2'b01; step(); frame_done = 1'b0;
        check("R10 no tx_en", tx_en, 0);
        check("R10 no rx_en", rx_en, 0);
        check("R10 no done_ok", done_ok, 0);
        ack_rx = 1'b1; step(); ack_rx = 1'b0;
        check("R6 ack ignored when idle", done_ok, 0);

        // No-ack policies, including reserved codes
        run_frame(2'b00, 0, 0);
        run_frame(2'b10, 2, 0);
        run_frame(2'b11, 1, 0);

        // Retry budget of 2, window 3: two retries, then failure
        ack_timeout = 16'd3; retry_limit = 4'd2;
        run_frame(2'b01, 1, 0);
        run_frame(2'b01, 0, 0);
        run_frame(2'b01, 0, 0);
        // Limit 0: fail at once
        retry_limit = 4'd0;
        run_frame(2'b01, 0, 0);
        // Ack on last cycle after one retry (R9)
        retry_limit = 4'd3; ack_timeout = 16'd4;
        run_frame(2'b01, 0, 0);
        run_frame(2'b01, 0, 4);
        // Timeout 0 behaves as a single cycle window, with collision on that cycle
        ack_timeout = 16'd0;
        run_frame(2'b01, 0, 1);

        // R2: tx_req ignored while listening
        ack_timeout = 16'd3; retry_limit = 4'd1;
        tx_req = 1'b1; step(); tx_req = 1'b0;
        frame_done = 1'b1; ack_policy = 2'b01; step(); frame_done = 1'b0;
        tx_req = 1'b1; step(); tx_req = 1'b0;
        check("R2 tx_req ignored while listening", tx_en, 0);
        check("R2 still listening", rx_en, 1);
        ack_rx = 1'b1; step(); ack_rx = 1'b0;
        check("R6 ack after ignored request", done_ok, 1);
        model_retry = 0;
        step();

        // Random frames
        for (int k = 0; k < 300; k++) begin
            logic [1:0] pol;
            int hold, ackc;
            if (model_retry == 0) begin
                ack_timeout = TW'($urandom_range(0, 6));
                retry_limit = RW'($urandom_range(0, 3));
            end
            pol  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
            hold = $urandom_range(0, 3);
            ackc = $urandom_range(0, window_len(ack_timeout) + 2);
            run_frame(pol, hold, ackc);
            if ($urandom_range(0, 3) == 0) step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule